// File: doc/BRIEF.md
# Line Zero-Run and Carrier-Loss Detector

This block watches a recovered bipolar line stream, delivered as a positive-rail and a negative-rail bit for each bit period, and derives four level flags for a status block to latch. Two flags report long strings of zeros (at least eight, at least sixteen). A third is a carrier-loss alarm with asymmetric hysteresis: it sets after a long unbroken zero run and clears only when enough ones arrive inside a window that opens at the first one received. The fourth is an all-ones (AIS) alarm judged once per fixed window of bit periods by how many zeros fell inside it.

Bits arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is always high, so every cycle with `in_valid` high delivers exactly one bit, and cycles with `in_valid` low are not bit periods at all. All counts and window lengths are parameters; the AIS window is given in bit periods (4632 corresponds to 3 ms at 1.544 Mb/s).

Top module: `line_zero_monitor`

## Requirements
- R1: A bit is accepted on every rising clock edge with `in_valid` high; `in_ready` is constantly 1. An accepted bit is a one when `rail_pos` or `rail_neg` (or both) is 1, otherwise a zero.
- R2: `zero8_det` is 1 from the cycle after the 8th consecutive accepted zero until the cycle after the next accepted one, regardless of how long the run grows.
- R3: `zero16_det` behaves the same way with a threshold of 16 consecutive zeros; it is never 1 while `zero8_det` is 0.
- R4: The zero-run count saturates rather than wrapping: after runs far longer than 192 zeros the run flags and the carrier-loss alarm stay 1.
- R5: `carrier_loss` rises in the cycle after the 192nd consecutive accepted zero, and not after the 191st.
- R6: While `carrier_loss` is 1, a clear window opens at the first accepted one; if the 14th one of the window arrives at or before window offset 111 (the opening one is offset 0), `carrier_loss` falls in the following cycle.
- R7: A clear window that reaches offset 111 with fewer than 14 ones closes without clearing; the next accepted one opens a new window, and ones from the old window no longer count.
- R8: Accepted bits are grouped from reset into back-to-back AIS windows of `AIS_WIN` bits. In the cycle after the last bit of each window, `ais_alarm` becomes 1 if that window held 5 or fewer zeros and 0 if it held 6 or more; it holds between window ends.
- R9: Cycles with `in_valid` low change no flag and advance no counter or window.
- R10: After reset all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A line bit is presented this cycle |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| rail_pos | input | 1 | Positive-rail bit of the presented period |
| rail_neg | input | 1 | Negative-rail bit of the presented period |
| zero8_det | output | 1 | At least 8 consecutive zeros received |
| zero16_det | output | 1 | At least 16 consecutive zeros received |
| carrier_loss | output | 1 | Carrier-loss alarm with set/clear hysteresis |
| ais_alarm | output | 1 | All-ones alarm, updated at each AIS window end |

## Verification
The zero that completes a 192-bit run can also be the last bit of an AIS window, so the carrier-loss set and the AIS verdict take effect on the same edge. The bench aligns the stream so that a zero run starts exactly on a window boundary, with the bench's AIS window shortened to 64 bits so that 192 zeros span three whole windows, and it checks that `carrier_loss` rises and `ais_alarm` reads 0 in that one cycle; a window wrap that disturbed the run count would leave the alarm unset. Clear-window edges are judged the same way, with ones placed at offsets 111 and 112.

// File: rtl/lzm_pkg.sv
package lzm_pkg;

  // State of the carrier-loss clear window.
  typedef enum logic {
    CLR_WAIT = 1'b0,  // alarm active, waiting for the first one
    CLR_OPEN = 1'b1   // window running, ones being counted
  } clr_state_e;

endpackage

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int SHORT_RUN = 8,
  parameter int LONG_RUN  = 16,
  parameter int SET_RUN   = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_one,
  output logic run_short,
  output logic run_long,
  output logic run_set_hit
);

  localparam int CW = $clog2(SET_RUN + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_RUN);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_RUN);
  localparam logic [CW-1:0] SET_C   = CW'(SET_RUN);
  localparam logic [CW-1:0] PRE_C   = CW'(SET_RUN - 1);

  logic [CW-1:0] run_q;

  // Count consecutive zeros, saturating at the carrier-loss threshold.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_vld) begin
      if (bit_one)             run_q <= '0;
      else if (run_q != SET_C) run_q <= run_q + 1'b1;
    end
  end

  assign run_short   = (run_q >= SHORT_C);
  assign run_long    = (run_q >= LONG_C);
  // This accepted zero is the one that completes the set run.
  assign run_set_hit = bit_vld && !bit_one && (run_q == PRE_C);

endmodule

// File: rtl/carrier_loss_tracker.sv
module carrier_loss_tracker
  import lzm_pkg::*;
#(
  parameter int CLR_WIN  = 112,
  parameter int CLR_ONES = 14   // must be 2 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_one,
  input  logic set_hit,
  output logic alarm
);

  localparam int PW = $clog2(CLR_WIN + 1);
  localparam int OW = $clog2(CLR_ONES + 1);
  localparam logic [PW-1:0] LAST_POS = PW'(CLR_WIN - 1);
  localparam logic [OW-1:0] ONES_PRE = OW'(CLR_ONES - 1);

  clr_state_e      st_q;
  logic [PW-1:0]   pos_q;
  logic [OW-1:0]   ones_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm  <= 1'b0;
      st_q   <= CLR_WAIT;
      pos_q  <= '0;
      ones_q <= '0;
    end else if (bit_vld) begin
      if (!alarm) begin
        if (set_hit) begin
          alarm <= 1'b1;
          st_q  <= CLR_WAIT;
        end
      end else begin
        unique case (st_q)
          CLR_WAIT: begin
            if (bit_one) begin
              st_q   <= CLR_OPEN;
              pos_q  <= PW'(1);
              ones_q <= OW'(1);
            end
          end
          CLR_OPEN: begin
            if (bit_one && ones_q == ONES_PRE) begin
              alarm <= 1'b0;
              st_q  <= CLR_WAIT;
            end else if (pos_q == LAST_POS) begin
              st_q <= CLR_WAIT;   // window failed, restart at next one
            end else begin
              pos_q  <= pos_q + 1'b1;
              ones_q <= ones_q + OW'(bit_one);
            end
          end
          default: st_q <= CLR_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/ais_window.sv
module ais_window #(
  parameter int WIN_BITS = 4632,
  parameter int MAX_ZERO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_one,
  output logic ais
);

  localparam int WW = $clog2(WIN_BITS);
  localparam int ZW = $clog2(MAX_ZERO + 2);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_BITS - 1);
  localparam logic [ZW-1:0] Z_SAT    = ZW'(MAX_ZERO + 1);
  localparam logic [ZW-1:0] Z_MAX    = ZW'(MAX_ZERO);

  logic [WW-1:0] wpos_q;
  logic [ZW-1:0] zc_q;
  logic [ZW-1:0] zc_nx;

  always_comb begin
    zc_nx = zc_q;
    if (!bit_one && zc_q != Z_SAT) zc_nx = zc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpos_q <= '0;
      zc_q   <= '0;
      ais    <= 1'b0;
    end else if (bit_vld) begin
      if (wpos_q == WIN_LAST) begin
        ais    <= (zc_nx <= Z_MAX);
        wpos_q <= '0;
        zc_q   <= '0;
      end else begin
        wpos_q <= wpos_q + 1'b1;
        zc_q   <= zc_nx;
      end
    end
  end

endmodule

// File: rtl/line_zero_monitor.sv
module line_zero_monitor #(
  parameter int SHORT_RUN = 8,
  parameter int LONG_RUN  = 16,
  parameter int LOSS_RUN  = 192,
  parameter int CLR_WIN   = 112,
  parameter int CLR_ONES  = 14,
  parameter int AIS_WIN   = 4632,
  parameter int AIS_MAXZ  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic rail_pos,
  input  logic rail_neg,
  output logic zero8_det,
  output logic zero16_det,
  output logic carrier_loss,
  output logic ais_alarm
);

  logic bit_vld;
  logic bit_one;
  logic set_hit;

  assign in_ready = 1'b1;
  assign bit_vld  = in_valid;
  assign bit_one  = rail_pos | rail_neg;

  zero_run_counter #(
    .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .SET_RUN(LOSS_RUN)
  ) u_run (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_one(bit_one),
    .run_short(zero8_det), .run_long(zero16_det), .run_set_hit(set_hit)
  );

  carrier_loss_tracker #(
    .CLR_WIN(CLR_WIN), .CLR_ONES(CLR_ONES)
  ) u_loss (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_one(bit_one),
    .set_hit(set_hit), .alarm(carrier_loss)
  );

  ais_window #(
    .WIN_BITS(AIS_WIN), .MAX_ZERO(AIS_MAXZ)
  ) u_ais (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_one(bit_one),
    .ais(ais_alarm)
  );

endmodule

// File: rtl/line_zero_monitor_chk.sv
module line_zero_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic rail_pos,
  input logic rail_neg,
  input logic zero8_det,
  input logic zero16_det,
  input logic carrier_loss,
  input logic ais_alarm
);

  p_long_within_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero16_det |-> zero8_det);

  p_one_ends_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (rail_pos || rail_neg)) |=> (!zero8_det && !zero16_det));

  p_loss_rise_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_loss) |-> $past(in_valid && !rail_pos && !rail_neg));

  p_loss_fall_on_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_loss) |-> $past(in_valid && (rail_pos || rail_neg)));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({zero8_det, zero16_det, carrier_loss, ais_alarm}));

  p_ais_moves_on_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais_alarm) |-> $past(in_valid));

endmodule

bind line_zero_monitor line_zero_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .rail_pos(rail_pos), .rail_neg(rail_neg),
  .zero8_det(zero8_det), .zero16_det(zero16_det),
  .carrier_loss(carrier_loss), .ais_alarm(ais_alarm)
);

// File: tb/tb_line_zero_monitor.sv
module tb_line_zero_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int TB_AIS_WIN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic rail_pos = 1'b0;
  logic rail_neg = 1'b0;
  logic in_ready, zero8_det, zero16_det, carrier_loss, ais_alarm;

  int checks = 0;
  int errors = 0;
  int bits_sent = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_zero_monitor #(.AIS_WIN(TB_AIS_WIN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rail_pos(rail_pos), .rail_neg(rail_neg),
    .zero8_det(zero8_det), .zero16_det(zero16_det),
    .carrier_loss(carrier_loss), .ais_alarm(ais_alarm)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    in_valid = 1'b1; rail_pos = p; rail_neg = n;
    @(posedge clk); #1;
    in_valid = 1'b0; rail_pos = 1'b0; rail_neg = 1'b0;
    bits_sent++;
  endtask

  task automatic send_zeros(input int cnt);
    for (int i = 0; i < cnt; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic send_ones(input int cnt);
    for (int i = 0; i < cnt; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0; rail_pos = 1'b1; rail_neg = 1'b1;
    @(posedge clk); #1;
    rail_pos = 1'b0; rail_neg = 1'b0;
  endtask

  task automatic align_window();
    while (bits_sent % TB_AIS_WIN != 0) send_bit(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk(zero8_det, 1'b0, "R10 zero8 after reset");
    chk(zero16_det, 1'b0, "R10 zero16 after reset");
    chk(carrier_loss, 1'b0, "R10 carrier_loss after reset");
    chk(ais_alarm, 1'b0, "R10 ais after reset");
    chk(in_ready, 1'b1, "R1 in_ready");
  endtask

  task automatic t_runs();
    send_zeros(7);
    chk(zero8_det, 1'b0, "R2 seven zeros");
    send_zeros(1);
    chk(zero8_det, 1'b1, "R2 eight zeros");
    chk(zero16_det, 1'b0, "R3 eight zeros");
    send_zeros(7);
    chk(zero16_det, 1'b0, "R3 fifteen zeros");
    send_zeros(1);
    chk(zero16_det, 1'b1, "R3 sixteen zeros");
    send_zeros(10);
    chk(zero8_det, 1'b1, "R2 longer run");
    send_bit(1'b0, 1'b1);
    chk(zero8_det, 1'b0, "R1 negative-rail one clears zero8");
    chk(zero16_det, 1'b0, "R1 negative-rail one clears zero16");
    send_zeros(7);
    send_bit(1'b1, 1'b1);
    send_zeros(1);
    chk(zero8_det, 1'b0, "R1 both-rail one restarts run");
  endtask

  task automatic t_idle();
    send_bit(1'b1, 1'b0);
    send_zeros(7);
    for (int i = 0; i < 5; i++) idle_cycle();
    chk(zero8_det, 1'b0, "R9 idle cycles not counted as zeros");
    send_zeros(1);
    chk(zero8_det, 1'b1, "R9 run resumes after idle");
    for (int i = 0; i < 3; i++) idle_cycle();
    chk(zero8_det, 1'b1, "R9 idle with rails high does not clear");
    send_bit(1'b1, 1'b0);
  endtask

  task automatic t_loss_set();
    send_bit(1'b1, 1'b0);
    send_zeros(191);
    chk(carrier_loss, 1'b0, "R5 after 191 zeros");
    send_zeros(1);
    chk(carrier_loss, 1'b1, "R5 after 192 zeros");
    send_zeros(108);
    chk(carrier_loss, 1'b1, "R4 alarm holds after 300 zeros");
    chk(zero8_det, 1'b1, "R4 zero8 holds after 300 zeros");
    chk(zero16_det, 1'b1, "R4 zero16 holds after 300 zeros");
  endtask

  task automatic t_loss_clear();
    send_ones(13);            // window offsets 0..12
    send_zeros(99);           // offsets 13..111
    chk(carrier_loss, 1'b1, "R7 window with 13 ones keeps alarm");
    send_bit(1'b1, 1'b0);     // offset 112 = new window offset 0
    chk(carrier_loss, 1'b1, "R7 one after window end opens new window");
    send_ones(12);            // offsets 1..12
    chk(carrier_loss, 1'b1, "R7 old ones not counted");
    send_zeros(98);           // offsets 13..110
    chk(carrier_loss, 1'b1, "R6 13 ones before last offset");
    send_bit(1'b0, 1'b1);     // offset 111, 14th one
    chk(carrier_loss, 1'b0, "R6 14th one at offset 111 clears");
    send_zeros(3);
    chk(carrier_loss, 1'b0, "R6 alarm stays clear");
  endtask

  task automatic t_ais();
    align_window();
    send_zeros(5); send_ones(59);
    chk(ais_alarm, 1'b1, "R8 window with 5 zeros");
    send_zeros(6); send_ones(57);
    chk(ais_alarm, 1'b1, "R8 holds until window end");
    send_ones(1);
    chk(ais_alarm, 1'b0, "R8 window with 6 zeros");
    send_ones(30); send_zeros(5); send_ones(29);
    chk(ais_alarm, 1'b1, "R8 window with 5 zeros mid-window");
  endtask

  task automatic t_coincide();
    // previous window ended with a one; run starts at a window boundary
    send_zeros(64);
    chk(ais_alarm, 1'b0, "R8 all-zero window");
    chk(carrier_loss, 1'b0, "R5 no alarm after 64 zeros");
    send_zeros(127);
    chk(carrier_loss, 1'b0, "R5 no alarm after 191 zeros");
    send_zeros(1);
    chk(carrier_loss, 1'b1, "R5 alarm when run end meets window end");
    chk(ais_alarm, 1'b0, "R8 verdict on same edge as alarm set");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_runs();
    t_idle();
    t_loss_set();
    t_loss_clear();
    t_ais();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule